// File: doc/BRIEF.md
# External Data-Memory Bus Controller

This block carries out single-byte data-memory reads and writes for an 8051-class processor core. Each request brings a 16-bit address, a direction flag, a write byte and a flag for the 8-bit register-indirect addressing form. The block decides whether the access lands in the on-chip expanded RAM or on the external bus. For an external access it runs a multiplexed bus cycle. The low address byte and the data byte share one bus, ALE marks the address phase for an external latch, the high address byte appears on the upper port, and active-low read and write strobes frame the data phase.

Two configuration inputs shape the routing. A 2-bit size code sets the expanded-RAM ceiling to 0x0100, 0x0200, 0x0400 or 0x0800. An external-only bit sends every access outward. A page mode keeps the upper port showing its general-purpose value during pointer cycles, so that port stays free for I/O. The strobe width is programmable in clocks. The expanded RAM sits behind a simple synchronous port whose read data appears one clock after the enable.

The controller is one state machine with seven states:
- `ST_IDLE` waits for a request. On `req_valid` it moves to `ST_INT` (internal) or `ST_ALE` (external).
- `ST_INT` issues the RAM enable, then moves to `ST_DONE`.
- `ST_ALE` drives the address with ALE high, then moves to `ST_HOLD`.
- `ST_HOLD` keeps the address with ALE low, loads the strobe counter, then moves to `ST_STROBE`.
- `ST_STROBE` holds RD or WR low. It stays there while the counter is non-zero and moves to `ST_RELEASE` when it reaches zero.
- `ST_RELEASE` raises the strobe, then moves to `ST_DONE`.
- `ST_DONE` pulses `done` and returns to `ST_IDLE`.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: With `cfg_ext_only`=0, a pointer access (`req_indirect`=0) whose address is below 0x100 shifted left by `cfg_xram_size` (0→0x0100, 1→0x0200, 2→0x0400, 3→0x0800) goes to expanded RAM at `xr_addr` = address[10:0]. An address equal to or above that limit goes to the external bus.
- R2: A pointer access at or above 0x0800 always runs an external cycle, for every size code.
- R3: A register-indirect access uses only address[7:0]. With `cfg_ext_only`=0 it goes to expanded RAM at `xr_addr` = {3'b000, address[7:0]}. As an external cycle it never drives `hi_addr_o`.
- R4: With `cfg_ext_only`=1, every access runs an external cycle, including pointer addresses below the size limit.
- R5: An external cycle accepted at clock edge 0 shows the following, with N = `cfg_strobe_len` and a value of 0 treated as 1. In cycle 1, `ale`=1 and `ad_oe`=1 with `ad_out` = address[7:0]. In cycle 2, `ale`=0 and the address is still driven. In cycles 3 to 2+N, the strobe is low. Cycle 3+N is a release cycle. `done`=1 in cycle 4+N.
- R6: On an external read, `ad_oe`=0 while `rd_n` is low. `rdata` holds the `ad_in` value sampled at the last strobe clock, and is valid while `done`=1.
- R7: On an external write, `wr_n` is low and `ad_out` carries the write byte with `ad_oe`=1 throughout the strobe and release cycles.
- R8: In cycles 1 to 3+N of an external pointer cycle with page mode off, `hi_addr_o` = address[15:8]. With page mode on, and at all other times, `hi_addr_o` = `gpio_hi`.
- R9: An expanded-RAM access asserts `xr_en` in cycle 1 only and raises `done` in cycle 2. It never asserts `ale`, `rd_n` low, `wr_n` low or `ad_oe`. A read returns the RAM's output as `rdata` while `done`=1.
- R10: `busy` is high from cycle 1 through the `done` cycle. A `req_valid` seen while busy is ignored: it starts no extra ALE, RAM enable or `done`.
- R11: `done` is a single-cycle pulse. RD and WR are never low together. ALE is never high while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = 8-bit register-indirect address form |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| cfg_ext_only | input | 1 | Send every access to the external bus |
| cfg_page_mode | input | 1 | Keep `gpio_hi` on the upper port during pointer cycles |
| cfg_xram_size | input | 2 | Expanded-RAM ceiling code |
| cfg_strobe_len | input | 4 | Strobe width in clocks (0 acts as 1) |
| gpio_hi | input | 8 | General-purpose value of the upper port |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read result, valid with `done` |
| xr_en | output | 1 | Expanded-RAM enable |
| xr_we | output | 1 | Expanded-RAM write enable |
| xr_addr | output | 11 | Expanded-RAM address |
| xr_wdata | output | 8 | Expanded-RAM write byte |
| xr_rdata | input | 8 | Expanded-RAM read byte, one clock after enable |
| hi_addr_o | output | 8 | Upper port output |
| ad_out | output | 8 | Shared address/data bus, outgoing value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus, incoming value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions assume that `rst_n` is held low before the first clock edge. They also assume that the request and configuration inputs change only between edges, so the accept edge sees settled values. The bench drives every input on the falling edge and lowers `req_valid` after the accept edge, except in the deliberate busy-time request test. It drives `ad_in` from a value latched during ALE, so the read byte is steady across the strobe window.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    localparam int XM_ADDR_W  = 16;
    localparam int XM_DATA_W  = 8;
    localparam int XM_SIZE_W  = 2;
    localparam int XM_CNT_W   = 4;
    localparam int XM_HI_W    = XM_ADDR_W - XM_DATA_W;
    localparam int XM_NSIZES  = 1 << XM_SIZE_W;
    localparam int XM_XR_AW   = XM_DATA_W + XM_NSIZES - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INT,
        ST_ALE,
        ST_HOLD,
        ST_STROBE,
        ST_RELEASE,
        ST_DONE
    } xm_state_e;

    typedef struct packed {
        logic                 write;
        logic                 indirect;
        logic                 internal;
        logic                 page;
        logic [XM_CNT_W-1:0]  len;
        logic [XM_ADDR_W-1:0] addr;
        logic [XM_DATA_W-1:0] wdata;
        logic [XM_XR_AW-1:0]  xaddr;
    } xm_req_t;
endpackage

// File: rtl/xmem_route.sv
module xmem_route
    import xmem_pkg::*;
(
    input  logic                 indirect_i,
    input  logic                 ext_only_i,
    input  logic [XM_SIZE_W-1:0] size_i,
    input  logic [XM_ADDR_W-1:0] addr_i,
    output logic                 internal_o,
    output logic [XM_XR_AW-1:0]  xaddr_o
);
    localparam logic [XM_ADDR_W-1:0] ONE = XM_ADDR_W'(1);

    logic [XM_ADDR_W-1:0] limit;

    always_comb begin
        limit = '0;
        for (int i = 0; i < XM_NSIZES; i++) begin
            if (size_i == XM_SIZE_W'(i)) begin
                limit = ONE << (XM_DATA_W + i);
            end
        end
    end

    always_comb begin
        internal_o = !ext_only_i && (indirect_i || (addr_i < limit));
        if (indirect_i) begin
            xaddr_o = XM_XR_AW'(addr_i[XM_DATA_W-1:0]);
        end else begin
            xaddr_o = addr_i[XM_XR_AW-1:0];
        end
    end
endmodule

// File: rtl/xmem_fsm.sv
module xmem_fsm
    import xmem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  xm_req_t              req_i,
    input  logic [XM_DATA_W-1:0] ad_in,
    output logic                 busy,
    output logic                 done,
    output logic                 ale,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 ad_oe,
    output logic                 addr_phase,
    output logic                 hi_active,
    output logic                 xr_en,
    output logic                 cur_write,
    output logic                 cur_indirect,
    output logic                 cur_internal,
    output logic                 cur_page,
    output logic [XM_ADDR_W-1:0] cur_addr,
    output logic [XM_DATA_W-1:0] cur_wdata,
    output logic [XM_XR_AW-1:0]  cur_xaddr,
    output logic [XM_DATA_W-1:0] rdata_q
);
    xm_state_e           state, nxt;
    xm_req_t             cur;
    logic [XM_CNT_W-1:0] cnt;
    logic                last_strobe;

    assign last_strobe = (state == ST_STROBE) && (cnt == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid) nxt = req_i.internal ? ST_INT : ST_ALE;
            ST_INT:     nxt = ST_DONE;
            ST_ALE:     nxt = ST_HOLD;
            ST_HOLD:    nxt = ST_STROBE;
            ST_STROBE:  if (cnt == '0) nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // request capture, strobe counter, read sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            cnt     <= '0;
            rdata_q <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                cur <= req_i;
            end
            if (state == ST_HOLD) begin
                cnt <= (cur.len == '0) ? '0 : cur.len - 1'b1;
            end else if (state == ST_STROBE && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (last_strobe && !cur.write) begin
                rdata_q <= ad_in;
            end
        end
    end

    // outputs per state
    always_comb begin
        busy       = 1'b1;
        done       = 1'b0;
        ale        = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        ad_oe      = 1'b0;
        addr_phase = 1'b0;
        hi_active  = 1'b0;
        xr_en      = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_INT:  xr_en = 1'b1;
            ST_ALE: begin
                ale        = 1'b1;
                ad_oe      = 1'b1;
                addr_phase = 1'b1;
                hi_active  = 1'b1;
            end
            ST_HOLD: begin
                ad_oe      = 1'b1;
                addr_phase = 1'b1;
                hi_active  = 1'b1;
            end
            ST_STROBE: begin
                rd_n      = cur.write;
                wr_n      = !cur.write;
                ad_oe     = cur.write;
                hi_active = 1'b1;
            end
            ST_RELEASE: begin
                ad_oe     = cur.write;
                hi_active = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign cur_write    = cur.write;
    assign cur_indirect = cur.indirect;
    assign cur_internal = cur.internal;
    assign cur_page     = cur.page;
    assign cur_addr     = cur.addr;
    assign cur_wdata    = cur.wdata;
    assign cur_xaddr    = cur.xaddr;
endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
    import xmem_pkg::*;
(
    input  logic                 addr_phase,
    input  logic                 ad_oe,
    input  logic                 hi_active,
    input  logic                 cur_indirect,
    input  logic                 cur_internal,
    input  logic                 cur_page,
    input  logic [XM_ADDR_W-1:0] cur_addr,
    input  logic [XM_DATA_W-1:0] cur_wdata,
    input  logic [XM_HI_W-1:0]   gpio_hi,
    input  logic [XM_DATA_W-1:0] rdata_q,
    input  logic [XM_DATA_W-1:0] xr_rdata,
    output logic [XM_HI_W-1:0]   hi_addr_o,
    output logic [XM_DATA_W-1:0] ad_out,
    output logic [XM_DATA_W-1:0] rdata
);
    logic drive_hi;

    assign drive_hi = hi_active && !cur_indirect && !cur_page;

    always_comb begin
        hi_addr_o = drive_hi ? cur_addr[XM_ADDR_W-1:XM_DATA_W] : gpio_hi;
        if (!ad_oe) begin
            ad_out = '0;
        end else if (addr_phase) begin
            ad_out = cur_addr[XM_DATA_W-1:0];
        end else begin
            ad_out = cur_wdata;
        end
        rdata = cur_internal ? xr_rdata : rdata_q;
    end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_indirect,
    input  logic [XM_ADDR_W-1:0] req_addr,
    input  logic [XM_DATA_W-1:0] req_wdata,
    input  logic                 cfg_ext_only,
    input  logic                 cfg_page_mode,
    input  logic [XM_SIZE_W-1:0] cfg_xram_size,
    input  logic [XM_CNT_W-1:0]  cfg_strobe_len,
    input  logic [XM_HI_W-1:0]   gpio_hi,
    output logic                 busy,
    output logic                 done,
    output logic [XM_DATA_W-1:0] rdata,
    output logic                 xr_en,
    output logic                 xr_we,
    output logic [XM_XR_AW-1:0]  xr_addr,
    output logic [XM_DATA_W-1:0] xr_wdata,
    input  logic [XM_DATA_W-1:0] xr_rdata,
    output logic [XM_HI_W-1:0]   hi_addr_o,
    output logic [XM_DATA_W-1:0] ad_out,
    output logic                 ad_oe,
    input  logic [XM_DATA_W-1:0] ad_in,
    output logic                 ale,
    output logic                 rd_n,
    output logic                 wr_n
);
    xm_req_t              req;
    logic                 internal;
    logic [XM_XR_AW-1:0]  xaddr;
    logic                 addr_phase, hi_active;
    logic                 cur_write, cur_indirect, cur_internal, cur_page;
    logic [XM_ADDR_W-1:0] cur_addr;
    logic [XM_DATA_W-1:0] cur_wdata, rdata_q;
    logic [XM_XR_AW-1:0]  cur_xaddr;

    xmem_route u_route (
        .indirect_i (req_indirect),
        .ext_only_i (cfg_ext_only),
        .size_i     (cfg_xram_size),
        .addr_i     (req_addr),
        .internal_o (internal),
        .xaddr_o    (xaddr)
    );

    always_comb begin
        req.write    = req_write;
        req.indirect = req_indirect;
        req.internal = internal;
        req.page     = cfg_page_mode;
        req.len      = cfg_strobe_len;
        req.addr     = req_addr;
        req.wdata    = req_wdata;
        req.xaddr    = xaddr;
    end

    xmem_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_i        (req),
        .ad_in        (ad_in),
        .busy         (busy),
        .done         (done),
        .ale          (ale),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .ad_oe        (ad_oe),
        .addr_phase   (addr_phase),
        .hi_active    (hi_active),
        .xr_en        (xr_en),
        .cur_write    (cur_write),
        .cur_indirect (cur_indirect),
        .cur_internal (cur_internal),
        .cur_page     (cur_page),
        .cur_addr     (cur_addr),
        .cur_wdata    (cur_wdata),
        .cur_xaddr    (cur_xaddr),
        .rdata_q      (rdata_q)
    );

    xmem_pins u_pins (
        .addr_phase   (addr_phase),
        .ad_oe        (ad_oe),
        .hi_active    (hi_active),
        .cur_indirect (cur_indirect),
        .cur_internal (cur_internal),
        .cur_page     (cur_page),
        .cur_addr     (cur_addr),
        .cur_wdata    (cur_wdata),
        .gpio_hi      (gpio_hi),
        .rdata_q      (rdata_q),
        .xr_rdata     (xr_rdata),
        .hi_addr_o    (hi_addr_o),
        .ad_out       (ad_out),
        .rdata        (rdata)
    );

    assign xr_we    = cur_write;
    assign xr_addr  = cur_xaddr;
    assign xr_wdata = cur_wdata;
endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk
    import xmem_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 busy,
    input logic                 done,
    input logic                 ale,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic                 ad_oe,
    input logic [XM_DATA_W-1:0] ad_out,
    input logic                 xr_en,
    input logic [XM_HI_W-1:0]   hi_addr_o,
    input logic [XM_HI_W-1:0]   gpio_hi
);
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_ale_off_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ale_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && ad_oe));

    p_read_bus_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    p_write_data_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> ($stable(ad_out) && ad_oe));

    p_idle_upper_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (hi_addr_o == gpio_hi));

    p_ram_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xr_en |-> (!ale && rd_n && wr_n && !ad_oe));

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .ad_out    (ad_out),
    .xr_en     (xr_en),
    .hi_addr_o (hi_addr_o),
    .gpio_hi   (gpio_hi)
);

// File: tb/tb_xmem_bus_ctrl.sv
module tb_xmem_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam logic [7:0] GPIO = 8'hC3;

    // vector: write, indirect, ext_only, page, size[2], len[4], addr[16], wdata[8], exp_internal
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2, 16'h00F0, 8'h00, 1'b1},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2, 16'h0100, 8'h00, 1'b0},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd2, 16'h01FF, 8'h00, 1'b1},
        {1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 4'd2, 16'h03FF, 8'h11, 1'b1},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 4'd2, 16'h07FF, 8'h00, 1'b1},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 4'd3, 16'h0800, 8'h00, 1'b0},
        {1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 4'd1, 16'hBEEF, 8'hA5, 1'b0},
        {1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd2, 16'hAB42, 8'h00, 1'b1},
        {1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd2, 16'h5577, 8'h3C, 1'b0},
        {1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 4'd0, 16'h0010, 8'h00, 1'b0},
        {1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd4, 16'h1234, 8'h00, 1'b0},
        {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'd5, 16'h00FF, 8'h99, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_indirect = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        cfg_ext_only = 1'b0, cfg_page_mode = 1'b0;
    logic [1:0]  cfg_xram_size = '0;
    logic [3:0]  cfg_strobe_len = 4'd1;
    logic [7:0]  gpio_hi = GPIO;
    logic        busy, done, xr_en, xr_we, ad_oe, ale, rd_n, wr_n;
    logic [7:0]  rdata, xr_wdata, hi_addr_o, ad_out, ad_in;
    logic [7:0]  xr_rdata = '0;
    logic [10:0] xr_addr;
    logic [7:0]  lat_lo = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xmem_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_indirect(req_indirect), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_ext_only(cfg_ext_only), .cfg_page_mode(cfg_page_mode),
        .cfg_xram_size(cfg_xram_size), .cfg_strobe_len(cfg_strobe_len),
        .gpio_hi(gpio_hi), .busy(busy), .done(done), .rdata(rdata),
        .xr_en(xr_en), .xr_we(xr_we), .xr_addr(xr_addr), .xr_wdata(xr_wdata),
        .xr_rdata(xr_rdata), .hi_addr_o(hi_addr_o), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    // expanded-RAM model: read data one clock after enable
    function automatic logic [7:0] ram_val(input logic [10:0] a);
        return a[7:0] + {5'b0, a[10:8]};
    endfunction

    always @(posedge clk) if (xr_en && !xr_we) xr_rdata <= ram_val(xr_addr);

    // external device: answers with the latched low address xor 5A
    always @(negedge clk) if (ale) lat_lo <= ad_out;
    assign ad_in = lat_lo ^ 8'h5A;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string route_tag(input logic ind, input logic ext, input logic [15:0] a);
        if (ext) return "R4";
        if (ind) return "R3";
        if (a >= 16'h0800) return "R2";
        return "R1";
    endfunction

    task automatic run_access(input logic [34:0] v, input int id);
        logic w, ind, ext, pg, exp_int;
        logic [1:0] sz;
        logic [3:0] ln;
        logic [15:0] a;
        logic [7:0] wd, exp_hi, got_rd;
        logic [10:0] exp_xa, got_xa;
        int eff_n, done_k, exp_done, bad_pins, bad_hi, xr_seen;
        bit got_we;
        w = v[34]; ind = v[33]; ext = v[32]; pg = v[31]; sz = v[30:29];
        ln = v[28:25]; a = v[24:9]; wd = v[8:1]; exp_int = v[0];
        eff_n = (ln == 0) ? 1 : int'(ln);
        exp_done = exp_int ? 2 : 4 + eff_n;
        exp_xa = ind ? {3'b000, a[7:0]} : a[10:0];
        done_k = 0; bad_pins = 0; bad_hi = 0; xr_seen = 0;
        got_rd = '0; got_xa = '0; got_we = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_indirect = ind; req_addr = a;
        req_wdata = wd; cfg_ext_only = ext; cfg_page_mode = pg;
        cfg_xram_size = sz; cfg_strobe_len = ln;
        @(negedge clk);
        for (int k = 1; k <= 30; k++) begin
            if (xr_en) begin
                xr_seen++;
                if (k != 1) bad_pins++;
                got_xa = xr_addr; got_we = xr_we;
            end
            if (exp_int) begin
                if (ale || !rd_n || !wr_n || ad_oe) bad_pins++;
                exp_hi = GPIO;
            end else begin
                if (ale != (k == 1)) bad_pins++;
                if (ad_oe != ((k <= 2) || (w && k >= 3 && k <= 3 + eff_n))) bad_pins++;
                if (rd_n != !(!w && k >= 3 && k <= 2 + eff_n)) bad_pins++;
                if (wr_n != !(w && k >= 3 && k <= 2 + eff_n)) bad_pins++;
                if (k <= 2 && ad_out != a[7:0]) bad_pins++;
                if (w && k >= 3 && k <= 3 + eff_n && ad_out != wd) bad_pins++;
                exp_hi = (k <= 3 + eff_n && !ind && !pg) ? a[15:8] : GPIO;
            end
            if (hi_addr_o != exp_hi) bad_hi++;
            if (busy != 1'b1) bad_pins++;
            if (k == 1) req_valid = 1'b0;
            if (done) begin
                done_k = k;
                got_rd = rdata;
                break;
            end
            @(negedge clk);
        end
        check(xr_seen == (exp_int ? 1 : 0), route_tag(ind, ext, a),
              $sformatf("vec %0d RAM enable count", id), xr_seen, exp_int ? 1 : 0);
        check(done_k == exp_done, exp_int ? "R9" : "R5/R11",
              $sformatf("vec %0d done cycle", id), done_k, exp_done);
        check(bad_pins == 0, exp_int ? "R9" : (w ? "R5/R7" : "R5/R6"),
              $sformatf("vec %0d bus pin mismatches", id), bad_pins, 0);
        check(bad_hi == 0, ind ? "R3" : "R8",
              $sformatf("vec %0d upper port mismatches", id), bad_hi, 0);
        if (exp_int) begin
            check(got_xa == exp_xa && got_we == w, ind ? "R3" : "R1",
                  $sformatf("vec %0d RAM address", id), got_xa, exp_xa);
            if (!w) check(got_rd == ram_val(exp_xa), "R9",
                          $sformatf("vec %0d RAM read data", id), got_rd, ram_val(exp_xa));
        end else if (!w) begin
            check(got_rd == (a[7:0] ^ 8'h5A), "R6",
                  $sformatf("vec %0d bus read data", id), got_rd, a[7:0] ^ 8'h5A);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int ale_cnt, xr_cnt, done_cnt, busy_bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(!busy && !done && !ale && rd_n && wr_n && !ad_oe && !xr_en && hi_addr_o == GPIO,
              "R10/R8", "idle pins after reset",
              {busy, done, ale, rd_n, wr_n, ad_oe, xr_en}, 7'b0001100);

        for (int i = 0; i < NVEC; i++) run_access(VEC[i], i);

        // R10: request raised during an external write is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_indirect = 1'b0; req_addr = 16'h2000;
        req_wdata = 8'h6B; cfg_ext_only = 1'b0; cfg_page_mode = 1'b0;
        cfg_xram_size = 2'd3; cfg_strobe_len = 4'd4;
        ale_cnt = 0; xr_cnt = 0; done_cnt = 0; busy_bad = 0;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            if (ale) ale_cnt++;
            if (xr_en) xr_cnt++;
            if (done) done_cnt++;
            if (busy != (k <= 8)) busy_bad++;
            if (k == 1) req_valid = 1'b0;
            if (k == 3) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0010;
            end
            if (k == 5) req_valid = 1'b0;
        end
        check(ale_cnt == 1 && xr_cnt == 0, "R10", "extra cycle from busy request",
              ale_cnt + xr_cnt, 1);
        check(done_cnt == 1 && busy_bad == 0, "R10", "done count / busy window",
              done_cnt * 100 + busy_bad, 100);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule